// File: doc/BRIEF.md
# Planar Graphics Write/Read Data Path

This block holds a small indexed register bank for a four-plane graphics memory and converts CPU bytes to and from the per-plane memory buses. Software first writes a register number to the index port, then writes or reads the selected register through the data port. The registers hold a per-plane fill colour, a per-plane fill enable, a reference colour, a per-plane comparison enable, and a mode word carrying a read mode and a write mode.

On a memory write in write mode 0, each plane takes either the CPU byte or, when its fill enable is set, a byte made entirely of copies of that plane's fill-colour bit. In the other write modes every plane takes the CPU byte. Memory writes use a valid/ready handshake. The ready signal is passed straight through from the plane memories, and the plane strobes fire in the same cycle as an accepted transfer. The requester must hold its data and valid until ready is seen high; nothing is queued inside the block.

On a memory read, the four incoming plane bytes are returned combinationally. In read mode 1 they are reduced to one byte by a colour match. In read mode 0 the byte of plane 0 is returned.

Top module: `gfx_plane_datapath`

## Requirements
- R1: After reset, every implemented register (indices 0x00, 0x01, 0x02, 0x05, 0x07) reads back as 0x00, and both modes are 0.
- R2: A write to the index port stores the byte as the current index. A data-port write stores into the register that index selects: 0x00 fill colour, 0x01 fill enable, 0x02 reference colour, 0x07 comparison enable (bits 3..0 each, one bit per plane 0..3), and 0x05 mode (bit 3 read mode, bits 1..0 write mode). Readback of a 4-bit register returns it in bits 3..0 with bits 7..4 at 0. Readback of 0x05 returns bit 3 and bits 1..0 as stored, with every other bit 0.
- R3: A data write to any other index changes no register, and a data read at such an index returns 0x00.
- R4: When the index port and the data port are strobed in the same cycle, the data goes to the register named by the index held before that cycle.
- R5: In write mode 0, plane p's output byte is the CPU byte when fill-enable bit p is 0, and is all-ones or all-zeros according to fill-colour bit p when fill-enable bit p is 1.
- R6: In write modes 1, 2 and 3, every plane's output byte is the CPU byte whatever the fill enable holds.
- R7: cpu_wr_ready equals plane_wr_ready. plane_we is 4'hF in exactly the cycles where cpu_wr_valid and plane_wr_ready are both high, and 4'h0 otherwise.
- R8: In read mode 1, bit i of cpu_rd_data is 1 exactly when every plane p whose comparison-enable bit is 1 has bit i of its byte equal to reference bit p. Plane p's byte occupies plane_rdata[8p+7:8p].
- R9: In read mode 1 with the comparison enable at 0x0, cpu_rd_data is 0xFF for any plane data.
- R10: In read mode 0, cpu_rd_data equals the plane 0 byte.
- R11: A memory write in the same cycle as a register data write is formed from the register values held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx_we | input | 1 | Strobe: load reg_wdata into the index |
| reg_data_we | input | 1 | Strobe: load reg_wdata into the selected register |
| reg_wdata | input | 8 | Byte for the index or data port |
| reg_rdata | output | 8 | Readback of the selected register |
| cpu_wr_valid | input | 1 | Memory write request |
| cpu_wr_ready | output | 1 | Memory write accepted this cycle |
| cpu_wr_data | input | 8 | CPU byte to be written |
| plane_wr_ready | input | 1 | Plane memories can take a write |
| plane_we | output | 4 | Per-plane write strobes |
| plane_wdata | output | 32 | Plane bytes, plane p in bits 8p+7..8p |
| plane_rdata | input | 32 | Plane bytes read, plane p in bits 8p+7..8p |
| cpu_rd_data | output | 8 | Byte returned to the CPU |

## Verification
Two pairs of functions can coincide in one cycle. A register data write can coincide with a memory write, and an index write can coincide with a data write. The first pair is provoked by presenting a fill-enable update and an accepted memory write in the same clock. The plane bytes seen before the edge must follow the old enable and those seen after it the new one. The second pair is provoked by strobing both register ports at once. It is judged by reading back both the register named by the old index and the register named by the new one.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int GFX_BYTE_W = 8;
  localparam int GFX_PLANES = 4;
  localparam int GFX_MODE_W = 2;

  // register numbers decoded from the index port
  localparam logic [GFX_BYTE_W-1:0] IDX_FILL_COLOR = 8'h00;
  localparam logic [GFX_BYTE_W-1:0] IDX_FILL_EN    = 8'h01;
  localparam logic [GFX_BYTE_W-1:0] IDX_REF_COLOR  = 8'h02;
  localparam logic [GFX_BYTE_W-1:0] IDX_MODE       = 8'h05;
  localparam logic [GFX_BYTE_W-1:0] IDX_CMP_EN     = 8'h07;

  // bit positions inside the mode register
  localparam int MODE_RD_BIT = 3;

  typedef enum logic [GFX_MODE_W-1:0] {
    WMODE_FILL = 2'd0,
    WMODE_1    = 2'd1,
    WMODE_2    = 2'd2,
    WMODE_3    = 2'd3
  } wr_mode_e;
endpackage

// File: rtl/gfx_regbank.sv
module gfx_regbank
  import gfx_pkg::*;
#(
  parameter int BYTE_W = GFX_BYTE_W,
  parameter int NPLANE = GFX_PLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [NPLANE-1:0] fill_color,
  output logic [NPLANE-1:0] fill_en,
  output logic [NPLANE-1:0] ref_color,
  output logic [NPLANE-1:0] cmp_en,
  output logic              rd_mode,
  output wr_mode_e          wr_mode
);
  logic [BYTE_W-1:0] idx_q;
  logic [NPLANE-1:0] fill_color_q, fill_en_q, ref_color_q, cmp_en_q;
  logic              rd_mode_q;
  wr_mode_e          wr_mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q        <= '0;
      fill_color_q <= '0;
      fill_en_q    <= '0;
      ref_color_q  <= '0;
      cmp_en_q     <= '0;
      rd_mode_q    <= 1'b0;
      wr_mode_q    <= WMODE_FILL;
    end else begin
      if (idx_we) idx_q <= wdata;
      if (data_we) begin
        case (idx_q)
          IDX_FILL_COLOR: fill_color_q <= wdata[NPLANE-1:0];
          IDX_FILL_EN:    fill_en_q    <= wdata[NPLANE-1:0];
          IDX_REF_COLOR:  ref_color_q  <= wdata[NPLANE-1:0];
          IDX_CMP_EN:     cmp_en_q     <= wdata[NPLANE-1:0];
          IDX_MODE: begin
            rd_mode_q <= wdata[MODE_RD_BIT];
            wr_mode_q <= wr_mode_e'(wdata[GFX_MODE_W-1:0]);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (idx_q)
      IDX_FILL_COLOR: rdata[NPLANE-1:0] = fill_color_q;
      IDX_FILL_EN:    rdata[NPLANE-1:0] = fill_en_q;
      IDX_REF_COLOR:  rdata[NPLANE-1:0] = ref_color_q;
      IDX_CMP_EN:     rdata[NPLANE-1:0] = cmp_en_q;
      IDX_MODE: begin
        rdata[MODE_RD_BIT]    = rd_mode_q;
        rdata[GFX_MODE_W-1:0] = wr_mode_q;
      end
      default: rdata = '0;
    endcase
  end

  assign fill_color = fill_color_q;
  assign fill_en    = fill_en_q;
  assign ref_color  = ref_color_q;
  assign cmp_en     = cmp_en_q;
  assign rd_mode    = rd_mode_q;
  assign wr_mode    = wr_mode_q;

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !idx_we |=> $stable(idx_q)); // R2
  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx_q == IDX_REF_COLOR) |=> ref_color_q == $past(wdata[NPLANE-1:0])); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_REF_COLOR) |-> rdata[BYTE_W-1:NPLANE] == '0); // R2
  AST_FILL_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx_q != IDX_FILL_EN) |=> $stable(fill_en_q)); // R3
endmodule

// File: rtl/gfx_wr_path.sv
module gfx_wr_path
  import gfx_pkg::*;
#(
  parameter int BYTE_W = GFX_BYTE_W,
  parameter int NPLANE = GFX_PLANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_wr_valid,
  input  logic [BYTE_W-1:0]        cpu_wr_data,
  input  logic                     plane_wr_ready,
  input  logic [NPLANE-1:0]        fill_color,
  input  logic [NPLANE-1:0]        fill_en,
  input  wr_mode_e                 wr_mode,
  output logic                     cpu_wr_ready,
  output logic [NPLANE-1:0]        plane_we,
  output logic [NPLANE*BYTE_W-1:0] plane_wdata
);
  logic fire;
  logic fill_mode;

  assign cpu_wr_ready = plane_wr_ready;
  assign fire         = cpu_wr_valid & plane_wr_ready;
  assign fill_mode    = (wr_mode == WMODE_FILL);
  assign plane_we     = {NPLANE{fire}};

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    logic force_fill;
    assign force_fill = fill_mode & fill_en[p];
    assign plane_wdata[p*BYTE_W +: BYTE_W] =
      force_fill ? {BYTE_W{fill_color[p]}} : cpu_wr_data;

    AST_FILL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode == WMODE_FILL && fill_en[p]) |->
        plane_wdata[p*BYTE_W +: BYTE_W] == {BYTE_W{fill_color[p]}}); // R5
    AST_CPU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode != WMODE_FILL || !fill_en[p]) |->
        plane_wdata[p*BYTE_W +: BYTE_W] == cpu_wr_data); // R6
  end

  AST_NO_STROBE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr_ready |-> plane_we == '0); // R7
  AST_STROBE_ONEHOT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_valid && cpu_wr_ready) |-> $countones(plane_we) == NPLANE); // R7
endmodule

// File: rtl/gfx_rd_path.sv
module gfx_rd_path
  import gfx_pkg::*;
#(
  parameter int BYTE_W = GFX_BYTE_W,
  parameter int NPLANE = GFX_PLANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPLANE*BYTE_W-1:0] plane_rdata,
  input  logic [NPLANE-1:0]        ref_color,
  input  logic [NPLANE-1:0]        cmp_en,
  input  logic                     rd_mode,
  output logic [BYTE_W-1:0]        cpu_rd_data
);
  logic [NPLANE-1:0][BYTE_W-1:0] agree;
  logic [BYTE_W-1:0]             match;

  for (genvar p = 0; p < NPLANE; p++) begin : g_cmp
    // a plane left out of the comparison agrees on every bit
    assign agree[p] = ~(plane_rdata[p*BYTE_W +: BYTE_W] ^ {BYTE_W{ref_color[p]}})
                      | {BYTE_W{~cmp_en[p]}};
  end

  always_comb begin
    match = '1;
    for (int p = 0; p < NPLANE; p++) match &= agree[p];
  end

  assign cpu_rd_data = rd_mode ? match : plane_rdata[BYTE_W-1:0];

  AST_NONE_ENABLED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && cmp_en == '0) |-> cpu_rd_data == '1); // R9
  AST_MODE0_PLANE0: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mode |-> cpu_rd_data == plane_rdata[BYTE_W-1:0]); // R10
endmodule

// File: rtl/gfx_plane_datapath.sv
module gfx_plane_datapath
  import gfx_pkg::*;
#(
  parameter int BYTE_W = GFX_BYTE_W,
  parameter int NPLANE = GFX_PLANES,
  localparam int BUS_W = NPLANE * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_idx_we,
  input  logic              reg_data_we,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cpu_wr_valid,
  output logic              cpu_wr_ready,
  input  logic [BYTE_W-1:0] cpu_wr_data,
  input  logic              plane_wr_ready,
  output logic [NPLANE-1:0] plane_we,
  output logic [BUS_W-1:0]  plane_wdata,
  input  logic [BUS_W-1:0]  plane_rdata,
  output logic [BYTE_W-1:0] cpu_rd_data
);
  logic [NPLANE-1:0] fill_color, fill_en, ref_color, cmp_en;
  logic              rd_mode;
  wr_mode_e          wr_mode;

  gfx_regbank #(.BYTE_W(BYTE_W), .NPLANE(NPLANE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (reg_idx_we),
    .data_we    (reg_data_we),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .fill_color (fill_color),
    .fill_en    (fill_en),
    .ref_color  (ref_color),
    .cmp_en     (cmp_en),
    .rd_mode    (rd_mode),
    .wr_mode    (wr_mode)
  );

  gfx_wr_path #(.BYTE_W(BYTE_W), .NPLANE(NPLANE)) u_wr (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_wr_valid   (cpu_wr_valid),
    .cpu_wr_data    (cpu_wr_data),
    .plane_wr_ready (plane_wr_ready),
    .fill_color     (fill_color),
    .fill_en        (fill_en),
    .wr_mode        (wr_mode),
    .cpu_wr_ready   (cpu_wr_ready),
    .plane_we       (plane_we),
    .plane_wdata    (plane_wdata)
  );

  gfx_rd_path #(.BYTE_W(BYTE_W), .NPLANE(NPLANE)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .plane_rdata (plane_rdata),
    .ref_color   (ref_color),
    .cmp_en      (cmp_en),
    .rd_mode     (rd_mode),
    .cpu_rd_data (cpu_rd_data)
  );

  AST_WR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_data_we && cpu_wr_valid && cpu_wr_ready) |-> plane_we != '0); // R11
endmodule

// File: tb/test_gfx_plane_datapath.sv
module test_gfx_plane_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_idx_we = 1'b0, reg_data_we = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        cpu_wr_valid = 1'b0, cpu_wr_ready;
  logic [7:0]  cpu_wr_data = '0;
  logic        plane_wr_ready = 1'b0;
  logic [3:0]  plane_we;
  logic [31:0] plane_wdata, plane_rdata = '0;
  logic [7:0]  cpu_rd_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gfx_plane_datapath i_gfx_plane_datapath (
    .clk(clk), .rst_n(rst_n), .reg_idx_we(reg_idx_we), .reg_data_we(reg_data_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_wr_valid(cpu_wr_valid),
    .cpu_wr_ready(cpu_wr_ready), .cpu_wr_data(cpu_wr_data), .plane_wr_ready(plane_wr_ready),
    .plane_we(plane_we), .plane_wdata(plane_wdata), .plane_rdata(plane_rdata),
    .cpu_rd_data(cpu_rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit iw, input bit dw, input logic [7:0] d);
    @(negedge clk);
    reg_idx_we = iw; reg_data_we = dw; reg_wdata = d;
    @(posedge clk); #1;
    reg_idx_we = 1'b0; reg_data_we = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
    strobe(1'b1, 1'b0, idx);
    strobe(1'b0, 1'b1, d);
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
    strobe(1'b1, 1'b0, idx);
    #2 v = reg_rdata;
  endtask

  function automatic logic [7:0] model_cmp(input logic [31:0] pl, input logic [3:0] rc,
                                           input logic [3:0] en);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      bit ok = 1'b1;
      for (int p = 0; p < 4; p++)
        if (en[p] && pl[p*8+i] != rc[p]) ok = 1'b0;
      r[i] = ok;
    end
    return r;
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    read_reg(8'h00, v); check("R1 fill colour", v, 8'h00);
    read_reg(8'h01, v); check("R1 fill enable", v, 8'h00);
    read_reg(8'h02, v); check("R1 reference", v, 8'h00);
    read_reg(8'h05, v); check("R1 mode", v, 8'h00);
    read_reg(8'h07, v); check("R1 compare enable", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    set_reg(8'h00, 8'hA5); read_reg(8'h00, v); check("R2 fill colour", v, 8'h05);
    set_reg(8'h01, 8'hFF); read_reg(8'h01, v); check("R2 fill enable", v, 8'h0F);
    set_reg(8'h02, 8'h3C); read_reg(8'h02, v); check("R2 reference", v, 8'h0C);
    set_reg(8'h07, 8'h97); read_reg(8'h07, v); check("R2 compare enable", v, 8'h07);
    set_reg(8'h05, 8'hFF); read_reg(8'h05, v); check("R2 mode", v, 8'h0B);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    set_reg(8'h03, 8'hFF); read_reg(8'h03, v); check("R3 read idx 03", v, 8'h00);
    set_reg(8'h81, 8'hFF); read_reg(8'h81, v); check("R3 read idx 81", v, 8'h00);
    read_reg(8'h00, v); check("R3 fill colour kept", v, 8'h05);
    read_reg(8'h01, v); check("R3 fill enable kept", v, 8'h0F);
    read_reg(8'h02, v); check("R3 reference kept", v, 8'h0C);
  endtask

  task automatic t_idx_and_data();
    logic [7:0] v;
    strobe(1'b1, 1'b0, 8'h02);
    strobe(1'b1, 1'b1, 8'h07);   // reference gets 7, index becomes 07
    #2 check("R4 new index readback", reg_rdata, 8'h07);
    read_reg(8'h02, v); check("R4 old index written", v, 8'h07);
  endtask

  task automatic t_write_mode0();
    set_reg(8'h05, 8'h00);
    set_reg(8'h00, 8'h0A);
    set_reg(8'h01, 8'h06);
    @(negedge clk); cpu_wr_data = 8'h5C; plane_wr_ready = 1'b1; cpu_wr_valid = 1'b1;
    #2 check("R5 partial fill", plane_wdata, 32'h5C00FF5C);
    set_reg(8'h00, 8'h03);
    set_reg(8'h01, 8'h0F);
    #2 check("R5 full fill", plane_wdata, 32'h0000FFFF);
    set_reg(8'h01, 8'h00);
    #2 check("R5 no fill", plane_wdata, 32'h5C5C5C5C);
    @(negedge clk); cpu_wr_valid = 1'b0;
  endtask

  task automatic t_write_other();
    set_reg(8'h00, 8'h05);
    set_reg(8'h01, 8'h0F);
    for (int m = 1; m < 4; m++) begin
      set_reg(8'h05, 8'(m));
      @(negedge clk); cpu_wr_data = 8'h90 + 8'(m);
      #2 check($sformatf("R6 write mode %0d", m), plane_wdata, {4{8'h90 + 8'(m)}});
    end
  endtask

  task automatic t_handshake();
    @(negedge clk); cpu_wr_valid = 1'b1; plane_wr_ready = 1'b0;
    #2 check("R7 stalled strobe", plane_we, 4'h0);
    check("R7 stalled ready", cpu_wr_ready, 1'b0);
    @(negedge clk); cpu_wr_valid = 1'b0; plane_wr_ready = 1'b1;
    #2 check("R7 idle strobe", plane_we, 4'h0);
    check("R7 ready passed", cpu_wr_ready, 1'b1);
    @(negedge clk); cpu_wr_valid = 1'b1;
    #2 check("R7 accepted strobe", plane_we, 4'hF);
    @(negedge clk); cpu_wr_valid = 1'b0;
  endtask

  task automatic t_read_mode1();
    set_reg(8'h05, 8'h08);
    set_reg(8'h02, 8'h05);
    set_reg(8'h07, 8'h0F);
    @(negedge clk); plane_rdata = 32'h00FF00FF;
    #2 check("R8 all match", cpu_rd_data, 8'hFF);
    @(negedge clk); plane_rdata = 32'h81FF00FF;
    #2 check("R8 plane3 mismatch", cpu_rd_data, 8'h7E);
    set_reg(8'h07, 8'h07);
    #2 check("R8 plane3 excluded", cpu_rd_data, 8'hFF);
    @(negedge clk); plane_rdata = 32'h3C5AA5C3;
    set_reg(8'h02, 8'h09); set_reg(8'h07, 8'h0B);
    #2 check("R8 mixed pattern", cpu_rd_data, model_cmp(32'h3C5AA5C3, 4'h9, 4'hB));
  endtask

  task automatic t_cmp_none();
    set_reg(8'h07, 8'h00);
    @(negedge clk); plane_rdata = 32'h12345678;
    #2 check("R9 no plane enabled", cpu_rd_data, 8'hFF);
  endtask

  task automatic t_read_mode0();
    set_reg(8'h05, 8'h00);
    @(negedge clk); plane_rdata = 32'hDEADBE5A;
    #2 check("R10 plane0 byte", cpu_rd_data, 8'h5A);
  endtask

  task automatic t_collision();
    set_reg(8'h05, 8'h00);
    set_reg(8'h00, 8'h0F);
    set_reg(8'h01, 8'h00);
    @(negedge clk);
    reg_data_we = 1'b1; reg_wdata = 8'h0F;
    cpu_wr_valid = 1'b1; plane_wr_ready = 1'b1; cpu_wr_data = 8'h33;
    #2 check("R11 old enable used", plane_wdata, 32'h33333333);
    check("R11 strobe fired", plane_we, 4'hF);
    @(posedge clk); #1;
    reg_data_we = 1'b0; cpu_wr_valid = 1'b0;
    #2 check("R11 new enable after edge", plane_wdata, 32'hFFFFFFFF);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL R1-watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_regs();
    t_unimpl();
    t_idx_and_data();
    t_write_mode0();
    t_write_other();
    t_handshake();
    t_read_mode1();
    t_cmp_none();
    t_read_mode0();
    t_collision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule